// File: doc/BRIEF.md
# Serial SRAM Link for a Bit-Serial Core

This block lets a bit-serial processor core reach an external SPI SRAM over one shared link. Instruction fetches, data loads and data stores all use that link. When the core raises a request, the block pulls chip select low and sends an 8-bit opcode. It then sends a 16-bit byte address and moves a data word, one bit per core clock. The serial clock runs at the core clock rate, so no bit is ever held in a parallel buffer.

Address and write data pass straight from the core's serial operand streams to the data-out pin. The block tells the core when it has taken a bit. Read data returns on a single-bit output with a valid strobe. The block relies on the SRAM's sequential mode, so the bytes of a word follow one address phase with no gaps. A single-cycle completion pulse marks the end of each transfer. A programmable number of chip-select-high cycles separates transfers, and a new request may be accepted in the last of those cycles.

Top module: `serial_mem_link`

## Requirements
- R1: While the synchronous active-low reset is held, and in the cycle after its release, chip select is high, the serial clock is low, `busy` and `done` are low, and `req_ready` is high.
- R2: A request of kind 2'b00 (fetch), 2'b01 (load) or 2'b11 (spare) is a read. Chip select goes low in the cycle after acceptance, and the first 8 serial clock cycles carry opcode 0x03, MSB first.
- R3: A request of kind 2'b10 (store) sends opcode 0x02, MSB first, in its first 8 serial clock cycles.
- R4: After the opcode, the 16 address bits are taken from `addr_bit`, MSB first. `addr_take` is high in each of those 16 cycles and low in every other cycle.
- R5: For a store, the next 16 cycles take `wdata_bit` (with `wdata_take` high) and drive it on the data-out pin. The first bit taken lands in bit 7 of the byte at the address, and the ninth lands in bit 7 of the next byte.
- R6: For a read, `rdata_valid` is high for 16 cycles. `rdata_bit` presents the data-in pin as sampled at each rising serial clock edge, in the same bit order as R5.
- R7: Every transfer has exactly 8+16+16 = 40 rising serial clock edges. Data out changes only while the serial clock is low. The serial clock stays low whenever chip select is high.
- R8: `done` is a one-cycle pulse in the cycle right after the last data bit, with chip select already high in that cycle.
- R9: Chip select stays high for at least GAP_CYCLES (default 2) cycles between transfers. A request held through a completion starts the next transfer after exactly GAP_CYCLES high cycles.
- R10: `req_ready` is low while bits move. A request raised during a transfer is ignored: it does not change the transfer in progress and does not start a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the serial clock runs at this rate |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core requests a transfer |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 spare (read) |
| req_ready | output | 1 | Request is accepted at the next edge if valid |
| addr_bit | input | 1 | Current address bit from the core, MSB first |
| addr_take | output | 1 | The address bit is consumed at the end of this cycle |
| wdata_bit | input | 1 | Current store data bit from the core |
| wdata_take | output | 1 | The store bit is consumed at the end of this cycle |
| rdata_bit | output | 1 | Read data bit for the core |
| rdata_valid | output | 1 | `rdata_bit` holds a fresh read bit this cycle |
| busy | output | 1 | A transfer or its trailing gap is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_csn | output | 1 | SRAM chip select, active low |
| mem_sck | output | 1 | SRAM serial clock (mode 0) |
| mem_mosi | output | 1 | Serial data to the SRAM |
| mem_miso | input | 1 | Serial data from the SRAM |

## Verification
The bound assertions check the framing properties on every cycle. After acceptance, chip select drops and the link becomes busy. Bit strobes appear only while chip select is low, and never together. The ready output stays low while bits move. Each transfer strobes exactly 16 address bits and 16 data bits before a single-cycle done pulse, which arrives with chip select high.

Other behaviours need a model of the SRAM in the bench. These are the opcode values, the MSB-first address and byte order, the round trip of stored data, the serial clock edge count, the gap length between back-to-back requests, and the harmlessness of a request raised mid-transfer.

// File: rtl/smem_pkg.sv
package smem_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'b00,
      KIND_LOAD  = 2'b01,
      KIND_STORE = 2'b10,
      KIND_SPARE = 2'b11
   } req_kind_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CMD,
      PH_ADDR,
      PH_DATA,
      PH_GAP
   } phase_e;

   localparam int OPCODE_BITS = 8;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/smem_sequencer.sv
module smem_sequencer
   import smem_pkg::*;
#(
   parameter int ADDR_BITS  = 16,
   parameter int DATA_BITS  = 16,
   parameter int GAP_CYCLES = 2,
   parameter int CNT_W      = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_kind,
   output logic       req_ready,
   output phase_e     phase,
   output logic [2:0] opcode_idx,
   output logic       is_write,
   output logic       busy,
   output logic       done
);

   localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPCODE_BITS - 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS - 1);
   localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYCLES - 1);

   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             wr_q, wr_d;
   logic             done_q, done_d;
   logic             cnt_zero;
   logic             may_start;

   assign cnt_zero  = (cnt_q == '0);
   assign may_start = (phase_q == PH_IDLE) || ((phase_q == PH_GAP) && cnt_zero);

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      wr_d    = wr_q;
      done_d  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               phase_d = PH_CMD;
               cnt_d   = OPC_LAST;
               wr_d    = (req_kind == KIND_STORE);
            end
         end
         PH_CMD: begin
            if (cnt_zero) begin
               phase_d = PH_ADDR;
               cnt_d   = ADDR_LAST;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_ADDR: begin
            if (cnt_zero) begin
               phase_d = PH_DATA;
               cnt_d   = DATA_LAST;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_DATA: begin
            if (cnt_zero) begin
               phase_d = PH_GAP;
               cnt_d   = GAP_LAST;
               done_d  = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_GAP: begin
            if (!cnt_zero) begin
               cnt_d = cnt_q - 1'b1;
            end else if (req_valid) begin
               phase_d = PH_CMD;
               cnt_d   = OPC_LAST;
               wr_d    = (req_kind == KIND_STORE);
            end else begin
               phase_d = PH_IDLE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         wr_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         wr_q    <= wr_d;
         done_q  <= done_d;
      end
   end

   assign req_ready  = may_start;
   assign phase      = phase_q;
   assign opcode_idx = cnt_q[2:0];
   assign is_write   = wr_q;
   assign busy       = (phase_q != PH_IDLE);
   assign done       = done_q;

endmodule

// File: rtl/smem_serdes.sv
module smem_serdes
   import smem_pkg::*;
#(
   parameter logic [7:0] OPC_READ  = 8'h03,
   parameter logic [7:0] OPC_WRITE = 8'h02
) (
   input  logic       clk,
   input  logic       rst_n,
   input  phase_e     phase,
   input  logic [2:0] opcode_idx,
   input  logic       is_write,
   input  logic       addr_bit,
   input  logic       wdata_bit,
   input  logic       mem_miso,
   output logic       addr_take,
   output logic       wdata_take,
   output logic       rdata_valid,
   output logic       rdata_bit,
   output logic       mem_csn,
   output logic       mem_sck,
   output logic       mem_mosi
);

   logic       link_on;
   logic [7:0] opcode;
   logic       rd_sample_q;

   assign link_on = (phase == PH_CMD) || (phase == PH_ADDR) || (phase == PH_DATA);
   assign opcode  = is_write ? OPC_WRITE : OPC_READ;

   always_comb begin
      unique case (phase)
         PH_CMD:  mem_mosi = opcode[opcode_idx];
         PH_ADDR: mem_mosi = addr_bit;
         PH_DATA: mem_mosi = is_write & wdata_bit;
         default: mem_mosi = 1'b0;
      endcase
   end

   assign addr_take   = (phase == PH_ADDR);
   assign wdata_take  = (phase == PH_DATA) && is_write;
   assign rdata_valid = (phase == PH_DATA) && !is_write;

   // Enable flips while clk is high, so the gated clock has no glitch:
   // its rising edge falls mid-cycle and its falling edge meets clk's rise.
   assign mem_sck = link_on & ~clk;
   assign mem_csn = ~link_on;

   // Read bits are captured where the serial clock rises.
   always_ff @(negedge clk) begin
      if (!rst_n) begin
         rd_sample_q <= 1'b0;
      end else begin
         rd_sample_q <= mem_miso;
      end
   end

   assign rdata_bit = rd_sample_q;

endmodule

// File: rtl/serial_mem_link.sv
module serial_mem_link
   import smem_pkg::*;
#(
   parameter int         ADDR_BITS  = 16,
   parameter int         DATA_BITS  = 16,
   parameter int         GAP_CYCLES = 2,
   parameter logic [7:0] OPC_READ   = 8'h03,
   parameter logic [7:0] OPC_WRITE  = 8'h02
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_kind,
   output logic       req_ready,
   input  logic       addr_bit,
   output logic       addr_take,
   input  logic       wdata_bit,
   output logic       wdata_take,
   output logic       rdata_bit,
   output logic       rdata_valid,
   output logic       busy,
   output logic       done,
   output logic       mem_csn,
   output logic       mem_sck,
   output logic       mem_mosi,
   input  logic       mem_miso
);

   localparam int LONGEST = max_of(max_of(OPCODE_BITS, ADDR_BITS), max_of(DATA_BITS, GAP_CYCLES));
   localparam int CNT_W   = max_of($clog2(LONGEST + 1), 3);

   if (ADDR_BITS < 8 || (ADDR_BITS % 8) != 0) begin : g_bad_addr
      $error("serial_mem_link: ADDR_BITS must be a nonzero multiple of 8");
   end
   if (DATA_BITS < 8 || (DATA_BITS % 8) != 0) begin : g_bad_data
      $error("serial_mem_link: DATA_BITS must be a nonzero multiple of 8");
   end
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("serial_mem_link: GAP_CYCLES must be at least 1");
   end

   phase_e     phase;
   logic [2:0] opcode_idx;
   logic       is_write;

   smem_sequencer #(
      .ADDR_BITS (ADDR_BITS),
      .DATA_BITS (DATA_BITS),
      .GAP_CYCLES(GAP_CYCLES),
      .CNT_W     (CNT_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_ready (req_ready),
      .phase     (phase),
      .opcode_idx(opcode_idx),
      .is_write  (is_write),
      .busy      (busy),
      .done      (done)
   );

   smem_serdes #(
      .OPC_READ (OPC_READ),
      .OPC_WRITE(OPC_WRITE)
   ) serdes_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .opcode_idx (opcode_idx),
      .is_write   (is_write),
      .addr_bit   (addr_bit),
      .wdata_bit  (wdata_bit),
      .mem_miso   (mem_miso),
      .addr_take  (addr_take),
      .wdata_take (wdata_take),
      .rdata_valid(rdata_valid),
      .rdata_bit  (rdata_bit),
      .mem_csn    (mem_csn),
      .mem_sck    (mem_sck),
      .mem_mosi   (mem_mosi)
   );

endmodule

// File: rtl/smem_link_checker.sv
module smem_link_checker #(
   parameter int ADDR_BITS = 16,
   parameter int DATA_BITS = 16
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic busy,
   input logic done,
   input logic mem_csn,
   input logic addr_take,
   input logic wdata_take,
   input logic rdata_valid
);

   localparam int CW = $clog2(ADDR_BITS + DATA_BITS + 1) + 1;

   logic [CW-1:0] a_cnt;
   logic [CW-1:0] d_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_cnt <= '0;
         d_cnt <= '0;
      end else if (req_valid && req_ready) begin
         a_cnt <= '0;
         d_cnt <= '0;
      end else begin
         if (addr_take) a_cnt <= a_cnt + 1'b1;
         if (wdata_take || rdata_valid) d_cnt <= d_cnt + 1'b1;
      end
   end

   p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!mem_csn && busy));

   p_strobe_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_take || wdata_take || rdata_valid) |-> !mem_csn);

   p_strobe_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_take, wdata_take, rdata_valid}));

   p_addr_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (a_cnt == CW'(ADDR_BITS)));

   p_data_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (d_cnt == CW'(DATA_BITS)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> mem_csn);

   p_idle_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> mem_csn);

   p_no_ready_moving_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_take || wdata_take || rdata_valid) |-> !req_ready);

endmodule

bind serial_mem_link smem_link_checker #(
   .ADDR_BITS(ADDR_BITS),
   .DATA_BITS(DATA_BITS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .busy       (busy),
   .done       (done),
   .mem_csn    (mem_csn),
   .addr_take  (addr_take),
   .wdata_take (wdata_take),
   .rdata_valid(rdata_valid)
);

// File: tb/serial_mem_link_tb_top.sv
`timescale 1ns/1ps
module serial_mem_link_tb_top;

   localparam int GAP = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'b00;
   logic       req_ready;
   logic       addr_bit = 1'b0;
   logic       addr_take;
   logic       wdata_bit = 1'b0;
   logic       wdata_take;
   logic       rdata_bit;
   logic       rdata_valid;
   logic       busy;
   logic       done;
   logic       mem_csn;
   logic       mem_sck;
   logic       mem_mosi;
   logic       mem_miso = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   serial_mem_link #(.GAP_CYCLES(GAP)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_kind   (req_kind),
      .req_ready  (req_ready),
      .addr_bit   (addr_bit),
      .addr_take  (addr_take),
      .wdata_bit  (wdata_bit),
      .wdata_take (wdata_take),
      .rdata_bit  (rdata_bit),
      .rdata_valid(rdata_valid),
      .busy       (busy),
      .done       (done),
      .mem_csn    (mem_csn),
      .mem_sck    (mem_sck),
      .mem_mosi   (mem_mosi),
      .mem_miso   (mem_miso)
   );

   // ---------------- SRAM model (sequential mode, mode 0) ----------------
   logic [7:0]  sram [0:255];
   int          m_cnt = 0;
   logic [7:0]  m_cmd = 8'h00;
   logic [15:0] m_addr = 16'h0000;
   logic [7:0]  m_sh = 8'h00;
   int          last_rises = 0;
   logic [7:0]  last_cmd = 8'h00;
   logic [15:0] last_addr = 16'h0000;

   always @(negedge mem_csn) m_cnt = 0;

   always @(posedge mem_sck) begin
      if (mem_csn === 1'b0) begin
         if (m_cnt < 8) m_cmd = {m_cmd[6:0], mem_mosi};
         else if (m_cnt < 24) m_addr = {m_addr[14:0], mem_mosi};
         else if (m_cmd == 8'h02) begin
            m_sh = {m_sh[6:0], mem_mosi};
            if (((m_cnt - 24) % 8) == 7)
               sram[(int'(m_addr[7:0]) + (m_cnt - 24) / 8) % 256] = m_sh;
         end
         m_cnt++;
      end
   end

   always @(negedge mem_sck) begin
      if (mem_csn === 1'b0 && m_cnt >= 24 && m_cmd == 8'h03)
         mem_miso = sram[(int'(m_addr[7:0]) + (m_cnt - 24) / 8) % 256][7 - ((m_cnt - 24) % 8)];
   end

   always @(posedge mem_csn) begin
      last_rises = m_cnt;
      last_cmd   = m_cmd;
      last_addr  = m_addr;
   end

   // ---------------- pin monitors ----------------
   int hi_run = 0;
   int last_gap = 0;
   int sck_while_idle = 0;
   int done_twice = 0;
   logic done_prev = 1'b0;

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (mem_csn === 1'b1) begin
            hi_run++;
            if (mem_sck !== 1'b0) sck_while_idle++;
         end else begin
            if (hi_run != 0) last_gap = hi_run;
            hi_run = 0;
         end
         if (done && done_prev) done_twice++;
         done_prev = done;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // Starts and ends at negedge+1; returns in the cycle where done is high.
   task automatic xfer(input logic [1:0] kind, input logic [15:0] a, input logic [15:0] w,
                       input int poke, output logic [15:0] r, output int n_addr,
                       output int n_wdata, output int n_rd, output int ready_in_frame,
                       output logic csn_at_done);
      bit acc = 0;
      int cyc = 0;
      r = '0; n_addr = 0; n_wdata = 0; n_rd = 0; ready_in_frame = 0; csn_at_done = 1'b0;
      req_kind  = kind;
      req_valid = 1'b1;
      while (!acc) begin
         acc = req_ready;
         @(posedge clk); #1;
      end
      req_valid = 1'b0;
      forever begin
         if (addr_take) begin
            if (n_addr < 16) addr_bit = a[15 - n_addr];
            n_addr++;
         end
         if (wdata_take) begin
            if (n_wdata < 16) wdata_bit = w[15 - n_wdata];
            n_wdata++;
         end
         if (!mem_csn && req_ready) ready_in_frame++;
         if (cyc == poke) begin
            req_valid = 1'b1;
            req_kind  = 2'b10;
         end else if (cyc == poke + 1) begin
            req_valid = 1'b0;
         end
         @(negedge clk); #1;
         if (rdata_valid) begin
            if (n_rd < 16) r[15 - n_rd] = rdata_bit;
            n_rd++;
         end
         if (done) begin
            csn_at_done = mem_csn;
            break;
         end
         @(posedge clk); #1;
         cyc++;
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk); #1;
      check("R1", "csn in reset", mem_csn, 1);
      check("R1", "sck in reset", mem_sck, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1", "csn after reset", mem_csn, 1);
      check("R1", "sck after reset", mem_sck, 0);
      check("R1", "busy after reset", busy, 0);
      check("R1", "done after reset", done, 0);
      check("R1", "ready after reset", req_ready, 1);
   endtask

   task automatic t_read(input logic [1:0] kind, input logic [15:0] a, input logic [15:0] word);
      logic [15:0] r;
      int na, nw, nr, rif;
      logic cd;
      sram[a[7:0]]        = word[15:8];
      sram[a[7:0] + 8'd1] = word[7:0];
      xfer(kind, a, 16'h0000, -10, r, na, nw, nr, rif, cd);
      check("R2", "read opcode", last_cmd, 8'h03);
      check("R4", "address seen by sram", last_addr, a);
      check("R4", "address strobes", na, 16);
      check("R6", "read word", r, word);
      check("R6", "read strobes", nr, 16);
      check("R7", "sck rising edges", last_rises, 40);
      check("R8", "csn high at done", cd, 1);
      check("R10", "ready during frame", rif, 0);
      wait_cycles(3);
   endtask

   task automatic t_store(input logic [15:0] a, input logic [15:0] w);
      logic [15:0] r;
      int na, nw, nr, rif;
      logic cd;
      xfer(2'b10, a, w, -10, r, na, nw, nr, rif, cd);
      check("R3", "write opcode", last_cmd, 8'h02);
      check("R4", "store address", last_addr, a);
      check("R5", "store strobes", nw, 16);
      check("R5", "first byte", sram[a[7:0]], w[15:8]);
      check("R5", "second byte", sram[a[7:0] + 8'd1], w[7:0]);
      check("R6", "no read strobes on store", nr, 0);
      check("R7", "sck rising edges store", last_rises, 40);
      wait_cycles(3);
      xfer(2'b01, a, 16'h0000, -10, r, na, nw, nr, rif, cd);
      check("R5", "store read back", r, w);
      wait_cycles(3);
   endtask

   task automatic t_back_to_back();
      logic [15:0] r;
      int na, nw, nr, rif;
      logic cd;
      sram[8'h50] = 8'h12;
      sram[8'h51] = 8'h34;
      xfer(2'b00, 16'h0050, 16'h0000, -10, r, na, nw, nr, rif, cd);
      check("R6", "first of pair", r, 16'h1234);
      xfer(2'b10, 16'h0060, 16'h9A7E, -10, r, na, nw, nr, rif, cd);
      check("R9", "csn high cycles between transfers", last_gap, GAP);
      check("R5", "second of pair stored", {sram[8'h60], sram[8'h61]}, 16'h9A7E);
      wait_cycles(3);
   endtask

   task automatic t_ignored_request();
      logic [15:0] r;
      int na, nw, nr, rif;
      int lows = 0;
      logic cd;
      sram[8'h30] = 8'h5A;
      sram[8'h31] = 8'hC3;
      sram[8'h70] = 8'hAA;
      xfer(2'b01, 16'h0030, 16'h0000, 5, r, na, nw, nr, rif, cd);
      check("R10", "read despite mid-frame request", r, 16'h5AC3);
      check("R10", "opcode unchanged", last_cmd, 8'h03);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); #1;
         if (mem_csn !== 1'b1) lows++;
      end
      check("R10", "no later transfer", lows, 0);
      check("R10", "memory untouched", sram[8'h30], 8'h5A);
   endtask

   // ---------------- main ----------------
   initial begin
      for (int i = 0; i < 256; i++) sram[i] = 8'(i * 7 + 1);
      t_reset();
      t_read(2'b00, 16'h1210, 16'hA53C);
      t_read(2'b01, 16'h0040, 16'h8001);
      t_read(2'b11, 16'hFFA2, 16'h6E19);
      t_store(16'h0020, 16'hBEEF);
      t_back_to_back();
      t_ignored_request();
      check("R7", "sck pulses while deselected", sck_while_idle, 0);
      check("R8", "done longer than one cycle", done_twice, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule